// File: doc/BRIEF.md
# Multi-link transmit sync controller

This block is the link-level sequencer of a serial transmitter that drives several links at once. Each link has an active-low synchronisation request line coming back from the receiving side. The block brings these lines into the local clock domain and masks out links that configuration has turned off. It then steps the transmitter through three phases. The first is code-group synchronisation. The second is an initial lane alignment phase that lasts a configured number of multiframes. The third is user data.

The outputs are a two-bit phase code, a ready flag for the user data path, and a read strobe with a small word address. The strobe and address fetch per-lane alignment configuration words from neighbouring logic. A manual request input lets software force the transmitter back into synchronisation at any time. Multiframe timing comes from a free-running beat counter, and the exit from synchronisation is lined up with the end of a multiframe.

Top module: `mltx_sync_ctrl`

## Requirements
- R1: Each `sync_n_i` bit passes through `SYNC_STAGES` (default 2) register stages before it can affect the state machine. A release at a pin is therefore seen no earlier than the third rising edge after it.
- R2: A 1 in `link_dis_i[k]` makes link k look released, whatever level its pin has. When all remaining enabled links are released, the block proceeds to the data phase even while a disabled link holds its pin low.
- R3: `phase_o` stays at 2'b00 (synchronisation) for as long as at least one enabled link has its synchronised request low.
- R4: A beat counter counts from 0 to `beats_cfg_i`, so a multiframe is `beats_cfg_i`+1 cycles long and its last beat is the boundary. Synchronisation ends only on a boundary cycle with no request pending. The first alignment cycle is therefore beat 0.
- R5: The alignment phase (2'b01) lasts `align_mf_cfg_i`+1 whole multiframes. The block then enters the data phase (2'b10) and never moves from synchronisation straight to data.
- R6: A request from any enabled link during the alignment or data phase returns the state machine to synchronisation on the next clock edge after the request is seen by the state machine.
- R7: While `manual_sync_i` is high, the phase returns to or stays at 2'b00 from the following edge, even with every link released.
- R8: `ready_o` is 1 only in the data phase.
- R9: `cfg_rd_o` is high in the alignment phase on beats 0 to `CFG_WORDS`-1 of each multiframe, with `cfg_addr_o` equal to the beat index. It is low at all other times.
- R10: A synchronous active-high `rst` puts the block in synchronisation with the beat and multiframe counters at 0, `ready_o` and `cfg_rd_o` at 0, and the synchroniser stages at the released level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n_i | input | N_LINKS | Per-link synchronisation request, active low, asynchronous |
| link_dis_i | input | N_LINKS | Per-link disable; 1 masks the link as released |
| beats_cfg_i | input | 8 | Beats per multiframe minus one |
| align_mf_cfg_i | input | 8 | Alignment-phase multiframes minus one |
| manual_sync_i | input | 1 | Software request to force synchronisation |
| phase_o | output | 2 | 00 sync, 01 alignment, 10 data |
| ready_o | output | 1 | User data accepted |
| cfg_rd_o | output | 1 | Configuration word read strobe |
| cfg_addr_o | output | CFG_ADDR_W | Configuration word address |

## Verification
The bench builds the block with two links, two synchroniser stages and four configuration words. Two links let the requests be released on different cycles in link order, and let one link be disabled while the other still runs the handshake. With a short multiframe setting, the boundary alignment, the exact alignment length and the read-strobe window can all be counted cycle by cycle. Random segments vary the multiframe length from 1 to 8 beats, including the one-beat case where every cycle is a boundary, and the strobe window wider than the multiframe.

// File: rtl/mltx_sync_pkg.sv
package mltx_sync_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'b00,
      PH_ALIGN = 2'b01,
      PH_DATA  = 2'b10
   } phase_e;

   localparam int CFG_W = 8;

endpackage

// File: rtl/mltx_sync_in.sv
module mltx_sync_in #(
   parameter int N_LINKS     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINKS-1:0] sync_n_i,
   input  logic [N_LINKS-1:0] link_dis_i,
   output logic               any_req_o
);

   logic [N_LINKS-1:0] synced;
   logic [N_LINKS-1:0] masked;

   generate
      if (N_LINKS < 1) begin : g_bad_links
         $error("mltx_sync_in: N_LINKS must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_stages
         $error("mltx_sync_in: SYNC_STAGES must not be negative");
      end

      if (SYNC_STAGES == 0) begin : g_bypass
         assign synced = sync_n_i;
      end else begin : g_chain
         logic [N_LINKS-1:0] pipe_q [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= '1;
            end else begin
               pipe_q[0] <= sync_n_i;
               for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign synced = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   // disabled links are forced to the released (high) level
   assign masked    = synced | link_dis_i;
   assign any_req_o = ~&masked;

   AST_DIS_MASK: assert property (@(posedge clk) disable iff (rst)
      (&link_dis_i) |-> !any_req_o);  // R2

endmodule

// File: rtl/mltx_mf_timer.sv
module mltx_mf_timer
   import mltx_sync_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [CFG_W-1:0] beats_cfg_i,
   output logic [CFG_W-1:0] beat_o,
   output logic             mf_end_o
);

   logic [CFG_W-1:0] beat_q;

   assign mf_end_o = (beat_q == beats_cfg_i);
   assign beat_o   = beat_q;

   always_ff @(posedge clk) begin
      if (rst)           beat_q <= '0;
      else if (mf_end_o) beat_q <= '0;
      else               beat_q <= beat_q + CFG_W'(1);
   end

   AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (rst)
      mf_end_o |=> (beat_o == '0));  // R4

endmodule

// File: rtl/mltx_phase_fsm.sv
module mltx_phase_fsm
   import mltx_sync_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             req_i,
   input  logic             mf_end_i,
   input  logic [CFG_W-1:0] align_mf_cfg_i,
   output phase_e           phase_o
);

   phase_e           state_q;
   logic [CFG_W-1:0] mf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PH_SYNC;
         mf_q    <= '0;
      end else begin
         unique case (state_q)
            PH_SYNC: begin
               mf_q <= '0;
               if (!req_i && mf_end_i) state_q <= PH_ALIGN;
            end
            PH_ALIGN: begin
               if (req_i) begin
                  state_q <= PH_SYNC;
                  mf_q    <= '0;
               end else if (mf_end_i) begin
                  if (mf_q == align_mf_cfg_i) state_q <= PH_DATA;
                  else                        mf_q    <= mf_q + CFG_W'(1);
               end
            end
            PH_DATA: begin
               if (req_i) begin
                  state_q <= PH_SYNC;
                  mf_q    <= '0;
               end
            end
            default: begin
               state_q <= PH_SYNC;
               mf_q    <= '0;
            end
         endcase
      end
   end

   assign phase_o = state_q;

   AST_SYNC_HELD: assert property (@(posedge clk) disable iff (rst)
      (state_q == PH_SYNC && req_i) |=> (state_q == PH_SYNC));  // R3
   AST_EXIT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      (state_q == PH_SYNC && !mf_end_i) |=> (state_q == PH_SYNC));  // R4
   AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
      (state_q == PH_SYNC) |=> (state_q != PH_DATA));  // R5
   AST_MF_BOUND: assert property (@(posedge clk) disable iff (rst)
      (state_q == PH_ALIGN) |-> (mf_q <= align_mf_cfg_i));  // R5
   AST_REQ_FORCES_SYNC: assert property (@(posedge clk) disable iff (rst)
      (state_q != PH_SYNC && req_i) |=> (state_q == PH_SYNC));  // R6

endmodule

// File: rtl/mltx_sync_ctrl.sv
module mltx_sync_ctrl
   import mltx_sync_pkg::*;
#(
   parameter int N_LINKS     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_WORDS   = 4,
   localparam int CFG_ADDR_W = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [N_LINKS-1:0]    sync_n_i,
   input  logic [N_LINKS-1:0]    link_dis_i,
   input  logic [7:0]            beats_cfg_i,
   input  logic [7:0]            align_mf_cfg_i,
   input  logic                  manual_sync_i,
   output logic [1:0]            phase_o,
   output logic                  ready_o,
   output logic                  cfg_rd_o,
   output logic [CFG_ADDR_W-1:0] cfg_addr_o
);

   localparam logic [CFG_W-1:0] WORDS_B = CFG_W'(CFG_WORDS);

   generate
      if (CFG_WORDS < 2 || (CFG_WORDS & (CFG_WORDS - 1)) != 0 || CFG_WORDS > 128) begin : g_bad_words
         $error("mltx_sync_ctrl: CFG_WORDS must be a power of two from 2 to 128");
      end
   endgenerate

   logic             link_req;
   logic             req;
   logic [CFG_W-1:0] beat;
   logic             mf_end;
   phase_e           phase;

   mltx_sync_in #(
      .N_LINKS     (N_LINKS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync_in (
      .clk        (clk),
      .rst        (rst),
      .sync_n_i   (sync_n_i),
      .link_dis_i (link_dis_i),
      .any_req_o  (link_req)
   );

   mltx_mf_timer u_timer (
      .clk         (clk),
      .rst         (rst),
      .beats_cfg_i (beats_cfg_i),
      .beat_o      (beat),
      .mf_end_o    (mf_end)
   );

   assign req = link_req | manual_sync_i;

   mltx_phase_fsm u_fsm (
      .clk            (clk),
      .rst            (rst),
      .req_i          (req),
      .mf_end_i       (mf_end),
      .align_mf_cfg_i (align_mf_cfg_i),
      .phase_o        (phase)
   );

   assign phase_o    = phase;
   assign ready_o    = (phase == PH_DATA);
   assign cfg_rd_o   = (phase == PH_ALIGN) && (beat < WORDS_B);
   assign cfg_addr_o = beat[CFG_ADDR_W-1:0];

   AST_RD_ONLY_ALIGN: assert property (@(posedge clk) disable iff (rst)
      cfg_rd_o |-> (phase_o == 2'b01));  // R9
   AST_MANUAL_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
      manual_sync_i |=> !ready_o);  // R7
   AST_READY_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
      ready_o |-> (phase_o == 2'b10));  // R8

endmodule

// File: tb/mltx_sync_ctrl_tb.sv
module mltx_sync_ctrl_tb;

   localparam int NL = 2;
   localparam int ST = 2;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NL-1:0] sync_n = '1;
   logic [NL-1:0] dis = '0;
   logic [7:0]    bpm = 8'd3;
   logic [7:0]    mpa = 8'd1;
   logic          man = 1'b0;
   logic [1:0]    phase;
   logic          ready;
   logic          rd;
   logic [1:0]    addr;

   int errors = 0;
   int checks = 0;
   int cyc_n = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mltx_sync_ctrl #(.N_LINKS(NL), .SYNC_STAGES(ST), .CFG_WORDS(CW)) u_dut (
      .clk(clk), .rst(rst), .sync_n_i(sync_n), .link_dis_i(dis),
      .beats_cfg_i(bpm), .align_mf_cfg_i(mpa), .manual_sync_i(man),
      .phase_o(phase), .ready_o(ready), .cfg_rd_o(rd), .cfg_addr_o(addr));

   // reference model built from the requirements
   logic [NL-1:0] m_s1, m_s2;
   logic [7:0]    m_beat, m_mf;
   logic [1:0]    m_st;
   wire m_end = (m_beat == bpm);
   wire m_req = (~&(m_s2 | dis)) | man;

   always @(posedge clk) begin
      if (rst) begin
         m_s1 <= '1; m_s2 <= '1; m_beat <= '0; m_mf <= '0; m_st <= 2'b00;
      end else begin
         m_s1 <= sync_n;
         m_s2 <= m_s1;
         m_beat <= m_end ? 8'd0 : m_beat + 8'd1;
         case (m_st)
            2'b00: begin m_mf <= '0; if (!m_req && m_end) m_st <= 2'b01; end
            2'b01: if (m_req) begin m_st <= 2'b00; m_mf <= '0; end
                   else if (m_end) begin
                      if (m_mf == mpa) m_st <= 2'b10; else m_mf <= m_mf + 8'd1;
                   end
            default: if (m_req) begin m_st <= 2'b00; m_mf <= '0; end
         endcase
      end
   end

   function automatic bit exp_ready(input logic [1:0] st);
      return st == 2'b10;
   endfunction
   function automatic bit exp_rd(input logic [1:0] st, input logic [7:0] b);
      return (st == 2'b01) && (b < CW);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc_n, act, exp);
      end
   endtask

   // one cycle: wait to the falling edge, compare against the model
   task automatic cyc();
      @(negedge clk);
      cyc_n++;
      chk(phase == m_st, "R3 R5 R6 phase vs model", phase, m_st);
      chk(ready == exp_ready(m_st), "R8 ready vs model", ready, exp_ready(m_st));
      chk(rd == exp_rd(m_st, m_beat) && (!rd || addr == m_beat[1:0]),
          "R9 strobe/addr vs model", {rd, addr}, {exp_rd(m_st, m_beat), m_beat[1:0]});
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) cyc();
      rst = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n, first, c1, acnt, rcnt;
      bit ok;
      void'($urandom(32'd20240611));

      // R10: reset state
      do_reset();
      rst = 1'b1;
      cyc();
      chk(phase == 2'b00 && !ready && !rd, "R10 reset outputs", {phase, ready, rd}, 0);
      rst = 1'b0;

      // directed: staggered releases, link order
      bpm = 8'd3; mpa = 8'd1; dis = '0; sync_n = 2'b00;
      do_reset();
      repeat (20) cyc();
      chk(phase == 2'b00, "R3 both links requesting", phase, 0);
      sync_n = 2'b01;
      repeat (6) cyc();
      chk(phase == 2'b00, "R3 link1 still requesting", phase, 0);
      sync_n = 2'b11; c1 = cyc_n;
      n = 0;
      while (phase == 2'b00 && n < 200) begin cyc(); n++; end
      first = cyc_n;
      chk(first - c1 >= 3, "R1 release latency", first - c1, 3);
      chk(phase == 2'b01, "R4 sync exits to alignment", phase, 1);
      chk(rd && addr == 2'd0, "R4 R9 first alignment cycle is beat 0", {rd, addr}, 4);
      acnt = 1; rcnt = rd;
      n = 0;
      while (n < 200) begin
         cyc(); n++;
         if (phase != 2'b01) break;
         acnt++; rcnt += rd;
      end
      chk(acnt == 8, "R5 alignment length cycles", acnt, 8);
      chk(rcnt == 8, "R9 read strobes in alignment", rcnt, 8);
      chk(phase == 2'b10 && ready, "R8 data phase ready", {phase, ready}, 5);

      // R6: link1 requests again during data
      sync_n = 2'b01;
      cyc(); cyc();
      chk(phase == 2'b10, "R6 request not yet through synchroniser", phase, 2);
      cyc();
      chk(phase == 2'b00 && !ready, "R6 back to sync, ready dropped", {phase, ready}, 0);

      // R2: disable link1 while it holds its pin low
      dis = 2'b10;
      n = 0;
      while (phase != 2'b10 && n < 200) begin cyc(); n++; end
      chk(phase == 2'b10, "R2 disabled low link ignored", phase, 2);
      ok = 1;
      for (int i = 0; i < 24; i++) begin
         if (i % 3 == 0) sync_n[1] = ~sync_n[1];
         cyc();
         if (phase != 2'b10) ok = 0;
      end
      chk(ok, "R2 disabled link toggling has no effect", ok, 1);

      // R7: manual request
      sync_n = 2'b11;
      man = 1'b1;
      cyc();
      chk(phase == 2'b00 && !ready, "R7 manual forces sync", phase, 0);
      ok = 1;
      for (int i = 0; i < 12; i++) begin cyc(); if (phase != 2'b00) ok = 0; end
      chk(ok, "R7 manual holds sync with links released", ok, 1);
      man = 1'b0;
      n = 0;
      while (phase != 2'b10 && n < 200) begin cyc(); n++; end
      chk(phase == 2'b10, "R7 recovery after manual release", phase, 2);

      // random segments against the model
      for (int seg = 0; seg < 4; seg++) begin
         bpm = 8'($urandom % 8);
         mpa = 8'($urandom % 4);
         dis = NL'($urandom % 4);
         sync_n = '1; man = 1'b0;
         do_reset();
         for (int i = 0; i < 2500; i++) begin
            cyc();
            for (int k = 0; k < NL; k++)
               if ($urandom % 50 == 0) sync_n[k] = ~sync_n[k];
            man = ($urandom % 300 == 0);
            if ($urandom % 700 == 0) dis = NL'($urandom % 4);
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule